// File: doc/BRIEF.md
# Binary image feature comparator

This block decides whether a black-and-white test image is a genuine copy of a stored reference image. It does not compare the whole image. It inspects two fixed regions. The first is a vertical dark stripe made of a range of columns that covers every row. The second is a right-angled triangular mark. Both images are 256 columns by 144 rows at one bit per pixel, which gives 36864 pixel addresses per image. Each image sits in a single-port synchronous memory that returns one pixel per clock. The controller therefore steps one address per cycle, with the pixel address equal to row*256 + column. A one-cycle delayed copy of the address and a delayed valid bit line up each pixel pair with the region logic.

A mismatch counter runs for each feature. Pixels outside both regions are skipped. A feature passes when its mismatch count is no larger than a tolerance parameter. The image is genuine only when both features pass. After the scan, a done flag and a pass bit report the verdict. A four-digit multiplexed seven-segment display spells REAL or FAKE. The display is blank while the block is idle or scanning.

Top module: `imgcmp_feature_top`

## Requirements
- R1: A start accepted on a clock edge scans all 36864 addresses at one per cycle, and done rises exactly 36865 rising edges after the accepting edge (not earlier).
- R2: Stripe region = columns STRIPE_LO..STRIPE_HI (default 100..103) in every row; a test pixel there that differs from the reference counts as a stripe mismatch, and a stripe count above MISS_TOL gives pass = 0.
- R3: Triangle region = rows TRI_R0..TRI_R0+TRI_H-1 (default 40..71), columns TRI_C0..TRI_C0+(row-TRI_R0) (default TRI_C0 = 180); differing pixels there count as triangle mismatches, and a count above MISS_TOL gives pass = 0.
- R4: Differences at pixels outside both regions have no effect on the verdict.
- R5: A feature passes when its mismatch count is at most MISS_TOL; pass = 1 only when both features pass (with MISS_TOL = 3, three triangle mismatches pass and four fail).
- R6: start is ignored while a scan or its final drain cycle is in progress; the scan neither restarts nor ends early.
- R7: done stays high until the next start; a start while done is high clears done on the accepting edge and begins a new scan.
- R8: pass is 1 (REAL) only while done is 1; with identical images it is 1.
- R9: While done is 0 the display is blank: seg = 7'h7F and an = 4'hF.
- R10: With done high, exactly one of an[3:0] is low at a time (active low, an[3] = leftmost), and seg (active low, bit0 = segment a ... bit6 = segment g) shows R,E,A,L or F,A,K,E left to right, with codes R=7'h2F, E=7'h06, A=7'h08, L=7'h47, F=7'h0E, K=7'h09.
- R11: A synchronous reset returns the block to idle with done = 0, pass = 0 and a blank display, even in the middle of a scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a scan; acted on when idle or done |
| done | output | 1 | Scan finished, verdict valid |
| pass | output | 1 | 1 = REAL, 0 = FAKE (valid with done) |
| seg | output | 7 | Segment pattern a..g, active low |
| an | output | 4 | Digit enables, active low, an[3] leftmost |

## Verification
The bench measures the scan length to the exact edge. A controller that drops the delayed valid bit, or that stops before the drain cycle, would raise done one cycle early and would miss the last pixel. It flips single pixels at the edge of each region: the first stripe column, and the triangle apex column on successive rows. A region decode that is off by one would then let a forged image through or reject a good one. It also places many flips outside both regions, where a loose decode would wrongly report FAKE. Tolerance is tested at exactly MISS_TOL and one above it, so that a strict versus inclusive comparison shows up. Start pulses in mid-scan and a reset in mid-scan check that the controller is neither restarted nor left running.

// File: rtl/imgcmp_pkg.sv
package imgcmp_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DRAIN, ST_DONE} scan_state_e;

  localparam logic [6:0] GLYPH_OFF = 7'h7F;

  // Column range test for the stripe feature.
  function automatic logic in_stripe(int col, int c_lo, int c_hi);
    return (col >= c_lo) && (col <= c_hi);
  endfunction

  // Right-angled triangle: each row below the apex widens by one column.
  function automatic logic in_tri(int row, int col, int r0, int h, int c0);
    return (row >= r0) && (row < r0 + h) && (col >= c0) && (col <= c0 + (row - r0));
  endfunction

  // Reference picture: both features dark plus a sparse background texture.
  function automatic logic base_pixel(int row, int col, int s_lo, int s_hi,
                                      int r0, int h, int c0);
    return in_stripe(col, s_lo, s_hi) || in_tri(row, col, r0, h, c0) ||
           (((row * 7 + col * 3) % 11) == 0);
  endfunction

  // Positions a test picture flips: stripe left edge, triangle apex column, column 0.
  function automatic logic flip_pixel(int row, int col, int s_lo, int r0, int c0,
                                      int n_s, int n_t, int n_b);
    return ((col == s_lo) && (row < n_s)) ||
           ((col == c0) && (row >= r0) && (row < r0 + n_t)) ||
           ((col == 0) && (row < n_b));
  endfunction

  // Active-low glyph for digit position pos (3 = leftmost).
  function automatic logic [6:0] word_glyph(logic is_real, logic [1:0] pos);
    logic [6:0] g;
    if (is_real) begin
      case (pos)
        2'd3: g = 7'h2F;
        2'd2: g = 7'h06;
        2'd1: g = 7'h08;
        default: g = 7'h47;
      endcase
    end else begin
      case (pos)
        2'd3: g = 7'h0E;
        2'd2: g = 7'h08;
        2'd1: g = 7'h09;
        default: g = 7'h06;
      endcase
    end
    return g;
  endfunction

endpackage

// File: rtl/imgcmp_pix_rom.sv
module imgcmp_pix_rom #(
  parameter int IMG_W  = 256,
  parameter int IMG_H  = 144,
  parameter int AW     = 16,
  parameter int S_LO   = 100,
  parameter int S_HI   = 103,
  parameter int T_R0   = 40,
  parameter int T_H    = 32,
  parameter int T_C0   = 180,
  parameter int FLIP_S = 0,
  parameter int FLIP_T = 0,
  parameter int FLIP_B = 0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic          pix
);
  import imgcmp_pkg::*;

  localparam int RW = $clog2(IMG_H);
  localparam int CW = $clog2(IMG_W);

  logic [IMG_W-1:0] rows_q [IMG_H];
  logic [RW-1:0]    row_idx;
  logic [CW-1:0]    col_idx;

  initial begin
    for (int r = 0; r < IMG_H; r++) begin
      for (int c = 0; c < IMG_W; c++) begin
        rows_q[RW'(r)][CW'(c)] = base_pixel(r, c, S_LO, S_HI, T_R0, T_H, T_C0) ^
                                 flip_pixel(r, c, S_LO, T_R0, T_C0, FLIP_S, FLIP_T, FLIP_B);
      end
    end
  end

  always_comb begin
    row_idx = RW'(int'(addr) / IMG_W);
    col_idx = CW'(int'(addr) % IMG_W);
  end

  // One pixel per clock, one cycle of read latency.
  always_ff @(posedge clk) pix <= rows_q[row_idx][col_idx];

endmodule

// File: rtl/imgcmp_feat_cnt.sv
module imgcmp_feat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             miss,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt <= '0;
    else if (miss && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R5: a saturated count never wraps back under the tolerance
  a_r5_cnt_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

  // R2: every mismatch below saturation adds exactly one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (miss && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/imgcmp_seg_drv.sv
module imgcmp_seg_drv #(
  parameter int REFRESH_W = 18
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       show,
  input  logic       is_real,
  output logic [6:0] seg,
  output logic [3:0] an
);
  import imgcmp_pkg::*;

  logic [REFRESH_W-1:0] refresh_q;
  logic [1:0]           digit_sel;

  always_ff @(posedge clk) begin
    if (rst) refresh_q <= '0;
    else     refresh_q <= refresh_q + 1'b1;
  end

  assign digit_sel = refresh_q[REFRESH_W-1 -: 2];

  always_comb begin
    if (show) begin
      an  = ~(4'b0001 << digit_sel);
      seg = word_glyph(is_real, digit_sel);
    end else begin
      an  = 4'hF;
      seg = GLYPH_OFF;
    end
  end

  // R10: at most one digit enabled at a time
  a_r10_one_digit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~an));

endmodule

// File: rtl/imgcmp_feature_top.sv
module imgcmp_feature_top #(
  parameter int IMG_W       = 256,
  parameter int IMG_H       = 144,
  parameter int STRIPE_LO   = 100,
  parameter int STRIPE_HI   = 103,
  parameter int TRI_R0      = 40,
  parameter int TRI_H       = 32,
  parameter int TRI_C0      = 180,
  parameter int MISS_TOL    = 0,
  parameter int CNT_W       = 16,
  parameter int REFRESH_W   = 18,
  parameter int TEST_FLIP_S = 0,
  parameter int TEST_FLIP_T = 0,
  parameter int TEST_FLIP_B = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       done,
  output logic       pass,
  output logic [6:0] seg,
  output logic [3:0] an
);
  import imgcmp_pkg::*;

  localparam int            NPIX     = IMG_W * IMG_H;
  localparam int            AW       = $clog2(NPIX);
  localparam logic [AW-1:0] LAST_A   = AW'(NPIX - 1);
  localparam logic [CNT_W-1:0] TOL_C = CNT_W'(MISS_TOL);

  scan_state_e      state_q;
  logic [AW-1:0]    addr_q, addr_d_q;
  logic             vld_d_q;
  logic             pix_ref, pix_tst;
  logic             accept_start;
  logic             pix_diff, stripe_miss, tri_miss;
  logic [CNT_W-1:0] stripe_cnt, tri_cnt;
  int               cmp_row, cmp_col;

  assign accept_start = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      addr_d_q <= '0;
      vld_d_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_SCAN: begin
          addr_d_q <= addr_q;
          vld_d_q  <= 1'b1;
          if (addr_q == LAST_A) state_q <= ST_DRAIN;
          else                  addr_q  <= addr_q + 1'b1;
        end
        ST_DRAIN: begin
          vld_d_q <= 1'b0;
          state_q <= ST_DONE;
        end
        default: begin
          vld_d_q <= 1'b0;
          if (accept_start) begin
            state_q <= ST_SCAN;
            addr_q  <= '0;
          end
        end
      endcase
    end
  end

  imgcmp_pix_rom #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW), .S_LO(STRIPE_LO), .S_HI(STRIPE_HI),
    .T_R0(TRI_R0), .T_H(TRI_H), .T_C0(TRI_C0), .FLIP_S(0), .FLIP_T(0), .FLIP_B(0)
  ) ref_rom_i (.clk(clk), .addr(addr_q), .pix(pix_ref));

  imgcmp_pix_rom #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW), .S_LO(STRIPE_LO), .S_HI(STRIPE_HI),
    .T_R0(TRI_R0), .T_H(TRI_H), .T_C0(TRI_C0), .FLIP_S(TEST_FLIP_S),
    .FLIP_T(TEST_FLIP_T), .FLIP_B(TEST_FLIP_B)
  ) tst_rom_i (.clk(clk), .addr(addr_q), .pix(pix_tst));

  // Compare stage works on the delayed address that matches the memory outputs.
  always_comb begin
    cmp_row     = int'(addr_d_q) / IMG_W;
    cmp_col     = int'(addr_d_q) % IMG_W;
    pix_diff    = vld_d_q && (pix_ref != pix_tst);
    stripe_miss = pix_diff && in_stripe(cmp_col, STRIPE_LO, STRIPE_HI);
    tri_miss    = pix_diff && in_tri(cmp_row, cmp_col, TRI_R0, TRI_H, TRI_C0);
  end

  imgcmp_feat_cnt #(.CNT_W(CNT_W)) stripe_cnt_i (
    .clk(clk), .rst(rst), .clr(accept_start), .miss(stripe_miss), .cnt(stripe_cnt));

  imgcmp_feat_cnt #(.CNT_W(CNT_W)) tri_cnt_i (
    .clk(clk), .rst(rst), .clr(accept_start), .miss(tri_miss), .cnt(tri_cnt));

  assign done = (state_q == ST_DONE);
  assign pass = done && (stripe_cnt <= TOL_C) && (tri_cnt <= TOL_C);

  imgcmp_seg_drv #(.REFRESH_W(REFRESH_W)) seg_drv_i (
    .clk(clk), .rst(rst), .show(done), .is_real(pass), .seg(seg), .an(an));

  // R1: the final address is followed by one drain cycle with valid data
  a_r1_last_drains: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN && addr_q == LAST_A) |=> (state_q == ST_DRAIN && vld_d_q));

  // R6: a start in mid-scan neither restarts nor stalls the address walk
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SCAN && start && addr_q != LAST_A) |=>
      (state_q == ST_SCAN && addr_q == $past(addr_q) + 1'b1));

  // R7: done holds until a start arrives
  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8: the verdict bit is only raised with done
  a_r8_pass_with_done: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  // R9: display dark whenever no verdict is shown
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    !done |-> (seg == 7'h7F && an == 4'hF));

  // R11: reset always lands in idle
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && !vld_d_q));

endmodule

// File: tb/imgcmp_feature_top_tb_top.sv
module imgcmp_feature_top_tb_top;

  localparam int NPIX = 256 * 144;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_main = 1'b0;
  logic start_rest = 1'b0;
  int   n_tests = 0;
  int   n_fail  = 0;

  always #5 clk = ~clk;

  // index: 0 dut_i, 1 stripe flip, 2 triangle flip, 3 background flips,
  //        4 tolerance ok, 5 tolerance exceeded
  logic       done_v [6];
  logic       pass_v [6];
  logic [6:0] seg_v  [6];
  logic [3:0] an_v   [6];

  imgcmp_feature_top #(.REFRESH_W(4)) dut_i (
    .clk(clk), .rst(rst), .start(start_main),
    .done(done_v[0]), .pass(pass_v[0]), .seg(seg_v[0]), .an(an_v[0]));
  imgcmp_feature_top #(.REFRESH_W(4), .TEST_FLIP_S(1)) st_i (
    .clk(clk), .rst(rst), .start(start_rest),
    .done(done_v[1]), .pass(pass_v[1]), .seg(seg_v[1]), .an(an_v[1]));
  imgcmp_feature_top #(.REFRESH_W(4), .TEST_FLIP_T(1)) tr_i (
    .clk(clk), .rst(rst), .start(start_rest),
    .done(done_v[2]), .pass(pass_v[2]), .seg(seg_v[2]), .an(an_v[2]));
  imgcmp_feature_top #(.REFRESH_W(4), .TEST_FLIP_B(20)) bg_i (
    .clk(clk), .rst(rst), .start(start_rest),
    .done(done_v[3]), .pass(pass_v[3]), .seg(seg_v[3]), .an(an_v[3]));
  imgcmp_feature_top #(.REFRESH_W(4), .TEST_FLIP_T(3), .MISS_TOL(3)) tok_i (
    .clk(clk), .rst(rst), .start(start_rest),
    .done(done_v[4]), .pass(pass_v[4]), .seg(seg_v[4]), .an(an_v[4]));
  imgcmp_feature_top #(.REFRESH_W(4), .TEST_FLIP_T(4), .MISS_TOL(3)) tbad_i (
    .clk(clk), .rst(rst), .start(start_rest),
    .done(done_v[5]), .pass(pass_v[5]), .seg(seg_v[5]), .an(an_v[5]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_glyph(bit genuine, int pos);
    logic [6:0] real_w [4] = '{7'h47, 7'h08, 7'h06, 7'h2F};
    logic [6:0] fake_w [4] = '{7'h06, 7'h09, 7'h08, 7'h0E};
    return genuine ? real_w[pos] : fake_w[pos];
  endfunction

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done_v[0] == 1'b0, "R11", "done after reset", done_v[0], 0);
    check(pass_v[0] == 1'b0, "R11", "pass after reset", pass_v[0], 0);
    check(seg_v[0] == 7'h7F && an_v[0] == 4'hF, "R9", "blank display idle",
          {an_v[0], seg_v[0]}, {4'hF, 7'h7F});
  endtask

  task automatic t_scan_timing();
    start_main = 1'b1;
    start_rest = 1'b1;
    @(negedge clk);
    start_main = 1'b0;
    start_rest = 1'b0;
    for (int i = 1; i <= NPIX; i++) begin
      if (i == 100 || i == NPIX - 1 || i == NPIX) start_main = 1'b1;
      @(negedge clk);
      start_main = 1'b0;
      if (i == 200)
        check(seg_v[0] == 7'h7F && an_v[0] == 4'hF, "R9", "blank display scanning",
              {an_v[0], seg_v[0]}, {4'hF, 7'h7F});
    end
    check(done_v[0] == 1'b0, "R6", "no early done after mid-scan starts", done_v[0], 0);
    check(done_v[1] == 1'b0, "R1", "done one edge before end", done_v[1], 0);
    @(negedge clk);
    check(done_v[0] == 1'b1, "R6", "scan ends on schedule despite starts", done_v[0], 1);
    check(done_v[1] == 1'b1, "R1", "done at edge 36865", done_v[1], 1);
  endtask

  task automatic t_verdicts();
    check(pass_v[0] == 1'b1, "R8", "identical images REAL", pass_v[0], 1);
    check(pass_v[1] == 1'b0, "R2", "one stripe flip FAKE", pass_v[1], 0);
    check(pass_v[2] == 1'b0, "R3", "one triangle apex flip FAKE", pass_v[2], 0);
    check(pass_v[3] == 1'b1, "R4", "background flips ignored", pass_v[3], 1);
    check(pass_v[4] == 1'b1, "R5", "misses equal to tolerance REAL", pass_v[4], 1);
    check(pass_v[5] == 1'b0, "R5", "misses above tolerance FAKE", pass_v[5], 0);
  endtask

  task automatic t_display(input int idx, input bit genuine);
    logic [3:0] seen = 4'h0;
    for (int k = 0; k < 20; k++) begin
      int pos = -1;
      for (int d = 0; d < 4; d++) if (an_v[idx] == ~(4'b0001 << d)) pos = d;
      check(pos >= 0, "R10", "exactly one digit enabled", an_v[idx], 0);
      if (pos >= 0) begin
        seen[pos] = 1'b1;
        check(seg_v[idx] == exp_glyph(genuine, pos), "R10", "digit glyph",
              seg_v[idx], exp_glyph(genuine, pos));
      end
      @(negedge clk);
    end
    check(seen == 4'hF, "R10", "all four digits refreshed", seen, 4'hF);
  endtask

  task automatic t_restart_and_reset();
    repeat (5) @(negedge clk);
    check(done_v[0] == 1'b1, "R7", "done held without start", done_v[0], 1);
    start_main = 1'b1;
    @(negedge clk);
    start_main = 1'b0;
    check(done_v[0] == 1'b0, "R7", "start in done clears done", done_v[0], 0);
    check(seg_v[0] == 7'h7F && an_v[0] == 4'hF, "R9", "blank after restart",
          {an_v[0], seg_v[0]}, {4'hF, 7'h7F});
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(done_v[0] == 1'b0 && pass_v[0] == 1'b0, "R11", "reset mid-scan",
          {done_v[0], pass_v[0]}, 0);
    check(done_v[1] == 1'b0, "R11", "reset clears done of finished unit", done_v[1], 0);
    repeat (NPIX + 10) @(negedge clk);
    check(done_v[0] == 1'b0, "R11", "reset left the block idle", done_v[0], 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_scan_timing();
    t_verdicts();
    t_display(0, 1'b1);
    t_display(1, 1'b0);
    t_restart_and_reset();
    finish_run();
  end

endmodule